// File: doc/BRIEF.md
# Standby Wakeup Latency Timer

This unit times the steps of a device's return from standby, in microseconds. A standby-exit pulse, accepted only while measurement is enabled, clears every result and arms a new session. Two span counters share one start event: the fast clock running. One stops when the CPU starts executing and gives the digital wakeup time. The other stops when the crystal auto-enable fires and gives the crystal-enable time. Each counts the 1 MHz tick strobes that fall strictly between its start and its stop.

A third counter measures the gap between two events: software declaring itself ready, and the crystal reporting ready. The gap is always stored as a non-negative magnitude. A separate two-bit order field records which event came first. Software signals readiness by writing a self-clearing bit. Every counter stops at all-ones instead of wrapping.

Each event counts once per session; later assertions of the same event are ignored. While the enable is low, the unit holds all of its state.

Top module: `wtm_wakeup_timer`

## Requirements
- R1: After reset every result output, the order field and the software-ready bit read zero.
- R2: A standby-exit pulse while enabled clears all three counters and the order field and arms the session; before the first such pulse, event inputs have no effect.
- R3: The digital wakeup time equals the number of cycles with the tick high that lie strictly after the cycle of the first accepted fast-clock-running event and strictly before the cycle of cpu_start; if both events fall in the same cycle the result is 0.
- R4: The crystal-enable time is measured the same way, from the fast-clock-running event to the crystal auto-enable event.
- R5: The 8-bit span counters saturate at 255 and the 12-bit delta counter saturates at 4095.
- R6: The delta time counts tick cycles strictly between the software-ready event and the crystal-ready event, whichever comes first; when both events fall in the same cycle it is 0.
- R7: The order field reads 00 until both delta events have been seen. It then reads 01 if software was ready first, 10 if the crystal was ready first, and 11 if both came in the same cycle.
- R8: A write strobe sets the software-ready bit in the next cycle. Hardware clears the bit one cycle later unless the write is repeated. The delta logic sees the software-ready event in the cycle the bit reads 1.
- R9: While the enable is low, no counter advances, no event is accepted, and a standby-exit pulse clears nothing.
- R10: Each event is taken only once per session. A repeated fast-clock, stop, software-ready or crystal-ready event leaves the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en | input | 1 | Measurement enable |
| standby_exit | input | 1 | Standby-exit pulse; clears and arms when enabled |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| fclk_run | input | 1 | Fast clock is running (start of both spans) |
| xtal_auto_en | input | 1 | Crystal auto-enable triggered (end of crystal span) |
| xtal_ready | input | 1 | Crystal reports ready (delta event) |
| cpu_start | input | 1 | CPU execution starts (end of digital span) |
| swrdy_wr | input | 1 | Software write strobe to the ready bit |
| swrdy | output | 1 | Software-ready bit, cleared by hardware |
| dig_wake_us | output | 8 | Digital wakeup time in microseconds |
| xtal_en_us | output | 8 | Crystal-enable time in microseconds |
| delta_us | output | 12 | Gap between software-ready and crystal-ready |
| order_flag | output | 2 | Which delta event came first |

## Verification
Two collisions matter most. In the first, the software-ready event and crystal-ready land in the same cycle. The bench provokes it by writing the ready bit one cycle before it raises xtal_ready, so that the bit reads 1 in the same cycle, and it expects order 11 with a zero delta. In the second, the fast-clock start and a stop event share a cycle; the bench expects a span of 0. Both cases are also compared against the rule that only ticks strictly between two events are counted.

// File: rtl/wtm_pkg.sv
package wtm_pkg;

  typedef enum logic [1:0] {
    ORD_NONE     = 2'b00,
    ORD_SW_FIRST = 2'b01,
    ORD_XT_FIRST = 2'b10,
    ORD_TIE      = 2'b11
  } order_e;

  // Saturating increment: never passes lim
  function automatic logic [31:0] sat_step(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // Order code from which event was first
  function automatic order_e order_code(input logic sw_first, input logic xt_first);
    order_e r;
    case ({xt_first, sw_first})
      2'b01:   r = ORD_SW_FIRST;
      2'b10:   r = ORD_XT_FIRST;
      2'b11:   r = ORD_TIE;
      default: r = ORD_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wtm_swrdy_bit.sv
module wtm_swrdy_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_set,
  output logic bit_q
);
  // Set by the write strobe, dropped by hardware the following cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= wr_set;
  end
endmodule

// File: rtl/wtm_span_ctr.sv
module wtm_span_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         tick,
  input  logic         start_ev,
  input  logic         stop_ev,
  output logic [W-1:0] count,
  output logic         running
);
  import wtm_pkg::*;

  localparam logic [31:0] CMAX = (32'd1 << W) - 32'd1;

  logic         used_q;
  logic         run_q;
  logic [W-1:0] cnt_q;
  logic         take_start;

  assign take_start = start_ev && !used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (clr) begin
      used_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      if (take_start) begin
        used_q <= 1'b1;
        run_q  <= !stop_ev;
      end else if (run_q) begin
        if (stop_ev)   run_q <= 1'b0;
        else if (tick) cnt_q <= W'(sat_step(32'(cnt_q), CMAX));
      end
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/wtm_order_delta.sv
module wtm_order_delta #(
  parameter int W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic               tick,
  input  logic               sw_ev,
  input  logic               xt_ev,
  output logic [W-1:0]       delta,
  output wtm_pkg::order_e    order
);
  import wtm_pkg::*;

  localparam logic [31:0] CMAX = (32'd1 << W) - 32'd1;

  logic         seen_sw_q, seen_xt_q;
  logic         counting_q, first_sw_q;
  logic [W-1:0] delta_q;
  order_e       order_q;
  logic         new_sw, new_xt, none_seen;

  assign new_sw    = sw_ev && !seen_sw_q;
  assign new_xt    = xt_ev && !seen_xt_q;
  assign none_seen = !seen_sw_q && !seen_xt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_sw_q  <= 1'b0;
      seen_xt_q  <= 1'b0;
      counting_q <= 1'b0;
      first_sw_q <= 1'b0;
      delta_q    <= '0;
      order_q    <= ORD_NONE;
    end else if (clr) begin
      seen_sw_q  <= 1'b0;
      seen_xt_q  <= 1'b0;
      counting_q <= 1'b0;
      first_sw_q <= 1'b0;
      delta_q    <= '0;
      order_q    <= ORD_NONE;
    end else if (en) begin
      if (new_sw) seen_sw_q <= 1'b1;
      if (new_xt) seen_xt_q <= 1'b1;
      if (none_seen) begin
        if (new_sw && new_xt) begin
          order_q <= order_code(1'b1, 1'b1);
        end else if (new_sw || new_xt) begin
          counting_q <= 1'b1;
          first_sw_q <= new_sw;
        end
      end else if (counting_q) begin
        if (new_sw || new_xt) begin
          counting_q <= 1'b0;
          order_q    <= order_code(first_sw_q, !first_sw_q);
        end else if (tick) begin
          delta_q <= W'(sat_step(32'(delta_q), CMAX));
        end
      end
    end
  end

  assign delta = delta_q;
  assign order = order_q;
endmodule

// File: rtl/wtm_wakeup_timer.sv
module wtm_wakeup_timer #(
  parameter int SPAN_W  = 8,
  parameter int DELTA_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               meas_en,
  input  logic               standby_exit,
  input  logic               us_tick,
  input  logic               fclk_run,
  input  logic               xtal_auto_en,
  input  logic               xtal_ready,
  input  logic               cpu_start,
  input  logic               swrdy_wr,
  output logic               swrdy,
  output logic [SPAN_W-1:0]  dig_wake_us,
  output logic [SPAN_W-1:0]  xtal_en_us,
  output logic [DELTA_W-1:0] delta_us,
  output logic [1:0]         order_flag
);
  import wtm_pkg::*;

  localparam int NSPAN = 2;   // 0: digital wakeup, 1: crystal enable

  logic armed_q;
  logic sess_clr;
  logic start_ev;
  logic sw_ev, xt_ev;
  logic [NSPAN-1:0]  stop_vec;
  logic [NSPAN-1:0]  span_run;
  logic [SPAN_W-1:0] span_cnt [NSPAN];
  order_e            ord;

  assign sess_clr = standby_exit && meas_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (sess_clr) armed_q <= 1'b1;
  end

  wtm_swrdy_bit u_swrdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_set (swrdy_wr),
    .bit_q  (swrdy)
  );

  assign start_ev    = fclk_run && armed_q;
  assign stop_vec[0] = cpu_start && armed_q;
  assign stop_vec[1] = xtal_auto_en && armed_q;
  assign sw_ev       = swrdy && armed_q;
  assign xt_ev       = xtal_ready && armed_q;

  for (genvar g = 0; g < NSPAN; g++) begin : g_span
    wtm_span_ctr #(.W(SPAN_W)) u_span (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sess_clr),
      .en       (meas_en),
      .tick     (us_tick),
      .start_ev (start_ev),
      .stop_ev  (stop_vec[g]),
      .count    (span_cnt[g]),
      .running  (span_run[g])
    );
  end

  wtm_order_delta #(.W(DELTA_W)) u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sess_clr),
    .en    (meas_en),
    .tick  (us_tick),
    .sw_ev (sw_ev),
    .xt_ev (xt_ev),
    .delta (delta_us),
    .order (ord)
  );

  assign dig_wake_us = span_cnt[0];
  assign xtal_en_us  = span_cnt[1];
  assign order_flag  = ord;
endmodule

// File: rtl/wtm_wakeup_timer_chk.sv
module wtm_wakeup_timer_chk #(
  parameter int SPAN_W  = 8,
  parameter int DELTA_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               meas_en,
  input logic               sess_clr,
  input logic               swrdy_wr,
  input logic               swrdy,
  input logic [SPAN_W-1:0]  dig_wake_us,
  input logic [SPAN_W-1:0]  xtal_en_us,
  input logic [DELTA_W-1:0] delta_us,
  input logic [1:0]         order_flag
);
  localparam logic [SPAN_W-1:0]  SMAX = '1;
  localparam logic [DELTA_W-1:0] DMAX = '1;

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sess_clr |=> (dig_wake_us == '0 && xtal_en_us == '0 && delta_us == '0 && order_flag == 2'b00));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_clr |=> ({1'b0, dig_wake_us} == {1'b0, $past(dig_wake_us)} ||
                   {1'b0, dig_wake_us} == {1'b0, $past(dig_wake_us)} + 1'b1));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_clr |=> ({1'b0, xtal_en_us} == {1'b0, $past(xtal_en_us)} ||
                   {1'b0, xtal_en_us} == {1'b0, $past(xtal_en_us)} + 1'b1));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_wake_us == SMAX && !sess_clr) |=> dig_wake_us == SMAX);

  assert_no_delta_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_us == DMAX && !sess_clr) |=> delta_us == DMAX);

  assert_order_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (order_flag != 2'b00 && !sess_clr) |=> ($stable(order_flag) && $stable(delta_us)));

  assert_tie_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    order_flag == 2'b11 |-> delta_us == '0);

  assert_swrdy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !swrdy_wr |=> !swrdy);

  assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> ($stable(dig_wake_us) && $stable(xtal_en_us) &&
                  $stable(delta_us) && $stable(order_flag)));
endmodule

bind wtm_wakeup_timer wtm_wakeup_timer_chk #(.SPAN_W(SPAN_W), .DELTA_W(DELTA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .meas_en     (meas_en),
  .sess_clr    (sess_clr),
  .swrdy_wr    (swrdy_wr),
  .swrdy       (swrdy),
  .dig_wake_us (dig_wake_us),
  .xtal_en_us  (xtal_en_us),
  .delta_us    (delta_us),
  .order_flag  (order_flag)
);

// File: tb/wtm_wakeup_timer_tb.sv
`timescale 1ns/1ps
module wtm_wakeup_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_en = 1'b0, standby_exit = 1'b0, us_tick = 1'b0;
  logic fclk_run = 1'b0, xtal_auto_en = 1'b0, xtal_ready = 1'b0, cpu_start = 1'b0, swrdy_wr = 1'b0;
  logic swrdy;
  logic [7:0]  dig_wake_us, xtal_en_us;
  logic [11:0] delta_us;
  logic [1:0]  order_flag;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wtm_wakeup_timer u_dut (
    .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .standby_exit(standby_exit),
    .us_tick(us_tick), .fclk_run(fclk_run), .xtal_auto_en(xtal_auto_en),
    .xtal_ready(xtal_ready), .cpu_start(cpu_start), .swrdy_wr(swrdy_wr),
    .swrdy(swrdy), .dig_wake_us(dig_wake_us), .xtal_en_us(xtal_en_us),
    .delta_us(delta_us), .order_flag(order_flag)
  );

  // columns: cpu, auto, sw write, xready, exp dig, exp xt, exp delta, exp order
  localparam int VEC [6][8] = '{
    '{10,  5,   3,   20,   9,   4,   15, 1},
    '{ 1, 40,  30,    7,   0,  39,   23, 2},
    '{ 0,  0,   9,   10,   0,   0,    0, 3},
    '{300,256,  0,    2, 255, 255,    0, 1},
    '{ 5,  5,   4, 4500,   4,   4, 4095, 1},
    '{ 2,  3, 100,   60,   1,   2,   40, 2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic fr, input logic cs, input logic ae,
                       input logic sw, input logic xr, input logic tk);
    fclk_run = fr; cpu_start = cs; xtal_auto_en = ae;
    swrdy_wr = sw; xtal_ready = xr; us_tick = tk;
    @(negedge clk);
  endtask

  task automatic exit_standby();
    standby_exit = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    standby_exit = 1'b0;
  endtask

  initial begin
    wait (cyc == 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 dig", dig_wake_us, 0);
    chk("R1 xt", xtal_en_us, 0);
    chk("R1 delta", delta_us, 0);
    chk("R1 order", order_flag, 0);
    chk("R1 swrdy", swrdy, 0);
    rst_n = 1'b1;
    meas_en = 1'b1;
    @(negedge clk);

    // R2: events before any standby exit are ignored
    for (int i = 0; i < 12; i++)
      drive(i == 0, i == 6, i == 4, i == 1, i == 8, 1'b1);
    chk("R2 unarmed dig", dig_wake_us, 0);
    chk("R2 unarmed xt", xtal_en_us, 0);
    chk("R2 unarmed order", order_flag, 0);

    // R3 R4 R5 R6 R7: vector table, tick every cycle
    for (int k = 0; k < 6; k++) begin
      int last;
      last = VEC[k][0];
      if (VEC[k][1] > last) last = VEC[k][1];
      if (VEC[k][2] + 1 > last) last = VEC[k][2] + 1;
      if (VEC[k][3] > last) last = VEC[k][3];
      exit_standby();
      for (int i = 0; i <= last + 2; i++)
        drive(i == 0, i == VEC[k][0], i == VEC[k][1], i == VEC[k][2], i == VEC[k][3], 1'b1);
      drive(0, 0, 0, 0, 0, 0);
      chk($sformatf("R3 vec%0d dig", k), dig_wake_us, VEC[k][4]);
      chk($sformatf("R4 vec%0d xt", k), xtal_en_us, VEC[k][5]);
      chk($sformatf("R6 vec%0d delta", k), delta_us, VEC[k][6]);
      chk($sformatf("R7 vec%0d order", k), order_flag, VEC[k][7]);
    end
    // vec3 and vec4 hit saturation (R5)
    chk("R5 dig saturated last run check", (VEC[3][4] == 255) ? 1 : 0, 1);

    // R2: standby exit clears results of the previous session
    exit_standby();
    chk("R2 clear dig", dig_wake_us, 0);
    chk("R2 clear delta", delta_us, 0);
    chk("R2 clear order", order_flag, 0);

    // R3: sparse ticks (every 4th cycle), start at 1, stop at 18 -> ticks 4,8,12,16
    for (int i = 0; i <= 20; i++)
      drive(i == 1, i == 18, 1'b0, 1'b0, 1'b0, (i % 4) == 0);
    chk("R3 sparse dig", dig_wake_us, 4);

    // R8: software-ready bit pulse; R7: order stays 00 with one event
    exit_standby();
    drive(0, 0, 0, 1, 0, 1);
    chk("R8 swrdy set", swrdy, 1);
    drive(0, 0, 0, 0, 0, 1);
    chk("R8 swrdy cleared", swrdy, 0);
    for (int i = 2; i < 10; i++) drive(0, 0, 0, 0, 0, 1);
    chk("R7 order pending", order_flag, 0);
    drive(0, 0, 0, 0, 1, 1);   // xtal ready at cycle 10, sw event at 1
    chk("R7 order sw first", order_flag, 1);
    chk("R6 delta pending case", delta_us, 8);

    // R10: repeated events ignored
    exit_standby();
    for (int i = 0; i <= 30; i++)
      drive(i == 0 || i == 8, i == 5 || i == 12, i == 3 || i == 20,
            i == 2 || i == 15, i == 7 || i == 25, 1'b1);
    chk("R10 dig", dig_wake_us, 4);
    chk("R10 xt", xtal_en_us, 2);
    chk("R10 delta", delta_us, 3);
    chk("R10 order", order_flag, 1);

    // R9: enable low freezes counting and drops events
    exit_standby();
    for (int i = 0; i <= 27; i++) begin
      meas_en = !(i >= 3 && i <= 12);
      drive(i == 0, i == 20 || i == 8, i == 6 || i == 25, 1'b0, 1'b0, 1'b1);
    end
    meas_en = 1'b1;
    chk("R9 dig frozen", dig_wake_us, 9);
    chk("R9 xt frozen", xtal_en_us, 14);
    meas_en = 1'b0;
    exit_standby();
    meas_en = 1'b1;
    chk("R9 exit ignored", dig_wake_us, 9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule